// File: doc/BRIEF.md
# Multi-Tile Threshold Halftone Screener

This block turns a raster stream of 8-bit grey pixels into a stream of 1-bit halftone pixels. Each incoming pixel is compared against a threshold read from a shared threshold memory. The memory is addressed as though the selected screen tile were stepped and repeated across the whole image. Up to four tiles live side by side in that memory. Each tile has its own width, height, base address and starting X/Y phase. A per-pixel tile select picks which tile screens that pixel.

Pixels enter on a valid/ready stream that carries start-of-frame and start-of-line markers. The binary result leaves on a second valid/ready stream. Back-pressure rules are as follows. An input beat is taken on a clock edge where `s_valid` and `s_ready` are both high. `s_ready` is high whenever the output register is empty or is being drained in the same cycle. While `m_valid` is high and `m_ready` is low, the output bit is held unchanged and no new pixel is taken.

The tile parameters are written through a small configuration port. The threshold memory is written through its own write port. Both are plain control pins with no handshake.

Top module: `halftone_screener`

## Requirements
- R1: `m_bit` is 1 when the pixel is strictly less than the threshold it was paired with, and 0 when the pixel equals or exceeds it.
- R2: Within a line, each tile's X position advances by one per accepted pixel and wraps to 0 after reaching the tile width minus one.
- R3: A start-of-line pixel that is not a start-of-frame pixel moves each tile's Y position forward by one, wrapping to 0 after the tile height minus one.
- R4: A start-of-frame pixel loads each tile's Y position from its Y phase and its X position from its X phase. A start-of-line pixel loads the X position from the X phase.
- R5: A phase value equal to or larger than the tile dimension is reduced modulo that dimension when it is loaded.
- R6: The threshold address is (base + y × width + x) modulo the memory depth (4096 entries by default).
- R7: All tile positions advance on every accepted pixel. The `s_tile` value sent with a pixel selects whose position, sizes and base form its address.
- R8: A pixel accepted at an edge appears on `m_valid`/`m_bit` after exactly that one edge. `m_valid` drops after a transfer when no new pixel is accepted.
- R9: `s_ready` equals `!m_valid || m_ready`. While `m_valid && !m_ready`, `m_valid` and `m_bit` stay stable.
- R10: After reset `m_valid` is 0. Every tile is 1×1 with base 0 and phases 0, so every pixel reads address 0.
- R11: A threshold write completes in one cycle. A pixel accepted on a later edge sees the new value.
- R12: Configuration writes use `cfg_field` codes 0 = width−1, 1 = height−1, 2 = base address, 3 = X phase, 4 = Y phase, applied to tile `cfg_tile`. Width and height each range from 1 to 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_tile | input | 2 | Tile addressed by the configuration write |
| cfg_field | input | 3 | Field code (see R12) |
| cfg_wdata | input | 12 | Configuration value |
| thr_we | input | 1 | Threshold memory write strobe |
| thr_waddr | input | 12 | Threshold memory write address |
| thr_wdata | input | 8 | Threshold value |
| s_valid | input | 1 | Input pixel valid |
| s_ready | output | 1 | Input pixel accepted when high with s_valid |
| s_pixel | input | 8 | Grey pixel value |
| s_sol | input | 1 | First pixel of a line |
| s_sof | input | 1 | First pixel of a frame (also a line start) |
| s_tile | input | 2 | Tile used to screen this pixel |
| m_valid | output | 1 | Output bit valid |
| m_ready | input | 1 | Downstream can take the output bit |
| m_bit | output | 1 | Halftone result |

## Verification
Properties check the stream rules on every cycle. These rules are the ready equation, the hold of the output bit under stall, and the single-edge latency with no spurious valid beats. They also check that the selected tile's X and Y positions never leave the tile when a pixel is taken. Only the bench's scenarios can show that the right threshold was chosen. This covers phase loading and reduction, wrap of the line and frame counters, address wrap past the end of memory, interleaved tile selection, and the strict less-than at equality. The bench checks these against an independent address model and a shadow copy of the threshold memory.

// File: rtl/hts_pkg.sv
package hts_pkg;
  // configuration field codes
  typedef enum logic [2:0] {
    FLD_XSIZE_M1 = 3'd0,
    FLD_YSIZE_M1 = 3'd1,
    FLD_BASE     = 3'd2,
    FLD_XPHASE   = 3'd3,
    FLD_YPHASE   = 3'd4
  } cfg_field_e;
endpackage

// File: rtl/hts_cfg_regs.sv
module hts_cfg_regs
  import hts_pkg::*;
#(
  parameter int NT  = 4,
  parameter int SZW = 6,
  parameter int AW  = 12,
  localparam int TW = $clog2(NT)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [TW-1:0]  cfg_tile,
  input  logic [2:0]     cfg_field,
  input  logic [AW-1:0]  cfg_wdata,
  output logic [SZW-1:0] xsm1 [NT],
  output logic [SZW-1:0] ysm1 [NT],
  output logic [AW-1:0]  base [NT],
  output logic [SZW-1:0] xph  [NT],
  output logic [SZW-1:0] yph  [NT]
);
  cfg_field_e fld;
  assign fld = cfg_field_e'(cfg_field);

  for (genvar t = 0; t < NT; t++) begin : g_tile
    logic hit;
    assign hit = cfg_we && (cfg_tile == TW'(t));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        xsm1[t] <= '0;
        ysm1[t] <= '0;
        base[t] <= '0;
        xph[t]  <= '0;
        yph[t]  <= '0;
      end else if (hit) begin
        case (fld)
          FLD_XSIZE_M1: xsm1[t] <= cfg_wdata[SZW-1:0];
          FLD_YSIZE_M1: ysm1[t] <= cfg_wdata[SZW-1:0];
          FLD_BASE:     base[t] <= cfg_wdata;
          FLD_XPHASE:   xph[t]  <= cfg_wdata[SZW-1:0];
          FLD_YPHASE:   yph[t]  <= cfg_wdata[SZW-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/hts_tile_tracker.sv
module hts_tile_tracker #(
  parameter int SZW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           adv,
  input  logic           sol,
  input  logic           sof,
  input  logic [SZW-1:0] xsm1,
  input  logic [SZW-1:0] ysm1,
  input  logic [SZW-1:0] xph,
  input  logic [SZW-1:0] yph,
  output logic [SZW-1:0] x_cur,
  output logic [SZW-1:0] y_cur
);
  localparam int SW1 = SZW + 1;

  logic [SZW-1:0] x_pos, y_pos;
  logic [SW1-1:0] xr_w, yr_w;
  logic [SZW-1:0] y_step;

  // phase reduced modulo the tile dimension at load time
  assign xr_w = SW1'(xph) % (SW1'(xsm1) + SW1'(1));
  assign yr_w = SW1'(yph) % (SW1'(ysm1) + SW1'(1));

  assign y_step = (y_pos >= ysm1) ? '0 : y_pos + SZW'(1);

  always_comb begin
    x_cur = (sol || sof) ? xr_w[SZW-1:0] : x_pos;
    if (sof)      y_cur = yr_w[SZW-1:0];
    else if (sol) y_cur = y_step;
    else          y_cur = y_pos;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_pos <= '0;
      y_pos <= '0;
    end else if (adv) begin
      x_pos <= (x_cur >= xsm1) ? '0 : x_cur + SZW'(1);
      y_pos <= y_cur;
    end
  end
endmodule

// File: rtl/hts_thresh_mem.sv
module hts_thresh_mem #(
  parameter int AW = 12,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/halftone_screener.sv
module halftone_screener #(
  parameter int NT    = 4,
  parameter int SZW   = 6,
  parameter int AW    = 12,
  parameter int PIX_W = 8,
  localparam int TW   = $clog2(NT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [TW-1:0]    cfg_tile,
  input  logic [2:0]       cfg_field,
  input  logic [AW-1:0]    cfg_wdata,
  input  logic             thr_we,
  input  logic [AW-1:0]    thr_waddr,
  input  logic [PIX_W-1:0] thr_wdata,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [PIX_W-1:0] s_pixel,
  input  logic             s_sol,
  input  logic             s_sof,
  input  logic [TW-1:0]    s_tile,
  output logic             m_valid,
  input  logic             m_ready,
  output logic             m_bit
);
  localparam int MW = 2 * SZW + 1;
  localparam int SW = AW + 2;

  logic [SZW-1:0] xsm1_a [NT];
  logic [SZW-1:0] ysm1_a [NT];
  logic [AW-1:0]  base_a [NT];
  logic [SZW-1:0] xph_a  [NT];
  logic [SZW-1:0] yph_a  [NT];
  logic [SZW-1:0] xc_a   [NT];
  logic [SZW-1:0] yc_a   [NT];

  logic             accept;
  logic [SZW-1:0]   sel_x, sel_y, sel_xsm1, sel_ysm1;
  logic [MW-1:0]    row_off;
  logic [SW-1:0]    addr_sum;
  logic [AW-1:0]    rd_addr;
  logic [PIX_W-1:0] thr_q;
  logic [PIX_W-1:0] pix_q;

  assign s_ready = !m_valid || m_ready;
  assign accept  = s_valid && s_ready;

  hts_cfg_regs #(.NT(NT), .SZW(SZW), .AW(AW)) cfg_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_tile(cfg_tile), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
    .xsm1(xsm1_a), .ysm1(ysm1_a), .base(base_a), .xph(xph_a), .yph(yph_a)
  );

  for (genvar t = 0; t < NT; t++) begin : g_trk
    hts_tile_tracker #(.SZW(SZW)) trk_i (
      .clk(clk), .rst_n(rst_n),
      .adv(accept), .sol(s_sol), .sof(s_sof),
      .xsm1(xsm1_a[t]), .ysm1(ysm1_a[t]), .xph(xph_a[t]), .yph(yph_a[t]),
      .x_cur(xc_a[t]), .y_cur(yc_a[t])
    );
  end

  assign sel_x    = xc_a[s_tile];
  assign sel_y    = yc_a[s_tile];
  assign sel_xsm1 = xsm1_a[s_tile];
  assign sel_ysm1 = ysm1_a[s_tile];

  // base + y * width + x, wrapped to the memory depth
  assign row_off  = MW'(sel_y) * (MW'(sel_xsm1) + MW'(1));
  assign addr_sum = SW'(base_a[s_tile]) + SW'(row_off) + SW'(sel_x);
  assign rd_addr  = addr_sum[AW-1:0];

  hts_thresh_mem #(.AW(AW), .DW(PIX_W)) mem_i (
    .clk(clk),
    .we(thr_we), .waddr(thr_waddr), .wdata(thr_wdata),
    .re(accept), .raddr(rd_addr), .rdata(thr_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      pix_q   <= '0;
    end else begin
      if (accept) begin
        m_valid <= 1'b1;
        pix_q   <= s_pixel;
      end else if (m_ready) begin
        m_valid <= 1'b0;
      end
    end
  end

  assign m_bit = pix_q < thr_q;
endmodule

// File: rtl/hts_checker.sv
module hts_checker #(
  parameter int SZW = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           s_valid,
  input logic           s_ready,
  input logic           m_valid,
  input logic           m_ready,
  input logic           m_bit,
  input logic [SZW-1:0] sel_x,
  input logic [SZW-1:0] sel_y,
  input logic [SZW-1:0] sel_xsm1,
  input logic [SZW-1:0] sel_ysm1
);
  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !m_valid |-> s_ready); // R9
  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |-> !s_ready); // R9
  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_bit))); // R9
  AST_ONE_EDGE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> m_valid); // R8
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (!(s_valid && s_ready) && !(m_valid && !m_ready)) |=> !m_valid); // R8
  AST_X_INSIDE_TILE: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |-> (sel_x <= sel_xsm1)); // R2
  AST_Y_INSIDE_TILE: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |-> (sel_y <= sel_ysm1)); // R3
endmodule

bind halftone_screener hts_checker #(.SZW(SZW)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .s_valid(s_valid), .s_ready(s_ready),
  .m_valid(m_valid), .m_ready(m_ready), .m_bit(m_bit),
  .sel_x(sel_x), .sel_y(sel_y), .sel_xsm1(sel_xsm1), .sel_ysm1(sel_ysm1)
);

// File: tb/halftone_screener_tb_top.sv
module halftone_screener_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0; logic [1:0] cfg_tile = 0; logic [2:0] cfg_field = 0; logic [11:0] cfg_wdata = 0;
  logic thr_we = 0; logic [11:0] thr_waddr = 0; logic [7:0] thr_wdata = 0;
  logic s_valid = 0, s_sol = 0, s_sof = 0; logic [7:0] s_pixel = 0; logic [1:0] s_tile = 0;
  logic s_ready, m_valid, m_bit;
  logic m_ready = 1'b1;

  always #10 clk = ~clk;

  halftone_screener dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_tile(cfg_tile), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
    .thr_we(thr_we), .thr_waddr(thr_waddr), .thr_wdata(thr_wdata),
    .s_valid(s_valid), .s_ready(s_ready), .s_pixel(s_pixel),
    .s_sol(s_sol), .s_sof(s_sof), .s_tile(s_tile),
    .m_valid(m_valid), .m_ready(m_ready), .m_bit(m_bit)
  );

  int checks = 0, fails = 0;
  bit bp_mode = 0;
  bit exp_q[$];
  string tag_q[$];

  // model state
  int tmem [4096];
  int msx[4], msy[4], mbase[4], mxph[4], myph[4], mx[4], my[4];

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // back-pressure generator
  always @(posedge clk) begin
    #1 m_ready = bp_mode ? (($urandom % 3) != 0) : 1'b1;
  end

  // monitor / scoreboard
  bit hold_pend = 0; bit hold_bit = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend) chk(m_valid && (m_bit == hold_bit), "R9 hold", int'(m_bit), int'(hold_bit));
      hold_pend = m_valid && !m_ready;
      hold_bit  = m_bit;
      if (m_valid && m_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R8 unexpected output", 1, 0);
        else begin
          bit e; string tg;
          e = exp_q.pop_front(); tg = tag_q.pop_front();
          chk(m_bit == e, tg, int'(m_bit), int'(e));
        end
      end
    end
  end

  task automatic cfg_write(int t, int f, int d);
    cfg_we = 1; cfg_tile = 2'(t); cfg_field = 3'(f); cfg_wdata = 12'(d);
    @(posedge clk); #1 cfg_we = 0;
  endtask

  // R12 field codes: 0 width-1, 1 height-1, 2 base, 3 xphase, 4 yphase
  task automatic set_tile(int t, int xs, int ys, int b, int xp, int yp);
    cfg_write(t, 0, xs - 1); cfg_write(t, 1, ys - 1); cfg_write(t, 2, b);
    cfg_write(t, 3, xp); cfg_write(t, 4, yp);
    msx[t] = xs; msy[t] = ys; mbase[t] = b; mxph[t] = xp; myph[t] = yp;
  endtask

  task automatic thr_write(int a, int d);
    thr_we = 1; thr_waddr = 12'(a); thr_wdata = 8'(d);
    @(posedge clk); #1 thr_we = 0;
    tmem[a] = d;
  endtask

  // pmode: 0 given value, 1 equal to threshold, 2 threshold-1, 3 random
  task automatic send_pix(int t, bit sol, bit sof, int pmode, int val, string tag);
    int addr = 0; int pix; int th;
    for (int k = 0; k < 4; k++) begin
      int x, y;
      x = (sol || sof) ? (mxph[k] % msx[k]) : mx[k];
      if (sof)      y = myph[k] % msy[k];
      else if (sol) y = (my[k] + 1) % msy[k];
      else          y = my[k];
      if (k == t) addr = (mbase[k] + y * msx[k] + x) % 4096;
      mx[k] = (x + 1) % msx[k]; my[k] = y;
    end
    th = tmem[addr];
    case (pmode)
      0: pix = val;
      1: pix = th;
      2: pix = (th == 0) ? 0 : th - 1;
      default: pix = int'($urandom % 256);
    endcase
    exp_q.push_back(pix < th); tag_q.push_back(tag);
    s_valid = 1; s_tile = 2'(t); s_sol = sol; s_sof = sof; s_pixel = 8'(pix);
    forever begin @(negedge clk); if (s_ready) break; end
    @(posedge clk); #1 s_valid = 0; s_sol = 0; s_sof = 0;
  endtask

  task automatic send_frame(int t, int lines, int len, int pmode, string tag);
    for (int l = 0; l < lines; l++)
      for (int i = 0; i < len; i++)
        send_pix((t < 0) ? (i % 4) : t, (i == 0), (l == 0 && i == 0),
                 (pmode < 0) ? (i % 2 + 1) : pmode, 0, tag);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk); #1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    for (int k = 0; k < 4; k++) begin
      msx[k] = 1; msy[k] = 1; mbase[k] = 0; mxph[k] = 0; myph[k] = 0; mx[k] = 0; my[k] = 0;
    end
    repeat (4) @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    chk(m_valid == 0, "R10 reset valid", int'(m_valid), 0);
    chk(s_ready == 1, "R10 reset ready", int'(s_ready), 1);
    @(posedge clk); #1;
    for (int a = 0; a < 4096; a++) thr_write(a, (a * 37 + 11) & 255);

    // default 1x1 tiles read address 0 (threshold 11)
    send_pix(0, 1, 1, 0, 10, "R10 default");
    send_pix(2, 0, 0, 0, 11, "R10 default");
    send_pix(3, 1, 0, 0, 200, "R10 default");
    drain();

    // R8 latency from idle
    @(negedge clk);
    chk(m_valid == 0, "R8 idle", int'(m_valid), 0);
    @(posedge clk); #1;
    send_pix(0, 1, 1, 3, 0, "R8 data");
    @(negedge clk);
    chk(m_valid == 1, "R8 latency", int'(m_valid), 1);
    @(posedge clk); #1;
    drain();

    set_tile(0, 4, 4, 0, 0, 0);
    send_frame(0, 6, 9, 3, "R2 R3 x/y wrap");
    send_frame(0, 2, 8, -1, "R1 equal/below threshold");
    set_tile(1, 5, 3, 100, 2, 1);
    send_frame(1, 4, 7, 3, "R4 phase load");
    set_tile(2, 3, 2, 300, 7, 5);
    send_frame(2, 3, 5, 3, "R5 phase reduce");
    set_tile(3, 64, 64, 4000, 60, 63);
    send_frame(3, 2, 8, 3, "R6 address wrap");
    send_frame(-1, 4, 10, 3, "R7 mixed tiles");
    bp_mode = 1;
    send_frame(-1, 3, 12, -1, "R9 back-pressure");
    send_frame(1, 3, 6, 3, "R9 back-pressure");
    drain();
    bp_mode = 0;
    drain();

    set_tile(0, 1, 1, 50, 0, 0);
    thr_write(50, 8'h80);
    send_pix(0, 1, 1, 0, 8'h7f, "R11 new threshold");
    thr_write(50, 8'h10);
    send_pix(0, 1, 1, 0, 8'h7f, "R11 rewritten threshold");
    drain();

    chk(exp_q.size() == 0, "R8 outstanding", exp_q.size(), 0);
    finish_run();
  end
endmodule